// File: doc/BRIEF.md
# SD Card SPI-Mode Data Block Reader

This block pulls one or more fixed-size data blocks from a memory card running in SPI mode. It is used after a read command has been issued and accepted elsewhere. A single `start` pulse latches the number of blocks, the block length in bytes and whether the checksum is enforced. From then on the block drives the serial clock itself, one byte exchange at a time. For every block it hunts for the start token and passes each payload byte to a downstream sink over a valid/ready byte interface. It then consumes the two trailing checksum bytes and, when asked to, compares them against a CRC16 it has accumulated over the payload.

The transfer ends with a one-cycle `done` pulse and a two-bit error code. The code separates three outcomes: a clean finish, a block whose token never arrived within the hunt budget, and a block whose checksum disagreed. While the sink holds off a payload byte, the serial link is frozen, so no card data is ever lost or buffered beyond one byte.

Top module: `sdrd_block_reader`

## Requirements
- R1: Every bit the block clocks out on `mosi` is 1. The serial clock idles low. `miso` is sampled on the rising edge of `sclk`, and each `sclk` half period lasts CLK_DIV clock cycles.
- R2: Each block starts with a token hunt. Bytes received before the start token 0xFE are discarded and never appear on `dout`.
- R3: The hunt examines at most HUNT_LIMIT bytes per block, and a token arriving as byte number HUNT_LIMIT is still accepted. If none of those bytes is 0xFE, the transfer ends with `err` = 2'b01 after exactly HUNT_LIMIT bytes have been read for that block.
- R4: After the token, exactly `blk_size` payload bytes are presented on `dout` in arrival order. They are followed by two checksum bytes that are read but never presented.
- R5: The checksum is CRC16 with polynomial 0x1021 and initial value 0, taken MSB first over the payload only. The first trailing byte is the high byte. With `crc_en` = 1, a mismatch ends the transfer with `err` = 2'b10 and no further byte is read.
- R6: With `crc_en` = 0, the trailing checksum bytes have no effect on the outcome.
- R7: With `blk_count` greater than one, every block gets its own token hunt with a fresh hunt budget. After the last block the transfer ends with `err` = 2'b00.
- R8: While `dout_valid` is high and `dout_ready` is low, `dout` stays unchanged and `sclk` does not toggle.
- R9: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted `start` through the `done` cycle, and `err` holds its value until the next accepted `start`.
- R10: A `start` pulse while `busy` is high is ignored.
- R11: A `start` with `blk_count` = 0 produces `done` with `err` = 2'b00 and no serial clock activity.
- R12: After reset, `busy`, `done`, `dout_valid` and `sclk` are low, `mosi` is high and `err` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| blk_count | input | CNT_W | Number of blocks to read |
| blk_size | input | SIZE_W | Payload bytes per block |
| crc_en | input | 1 | Enforce the checksum comparison |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 2 | 00 ok, 01 token timeout, 10 checksum mismatch |
| sclk | output | 1 | Serial clock to the card |
| mosi | output | 1 | Serial data to the card (held high) |
| miso | input | 1 | Serial data from the card |
| dout | output | 8 | Payload byte |
| dout_valid | output | 1 | Payload byte available |
| dout_ready | input | 1 | Sink accepts the payload byte |

## Verification
The hardest situations to reach are the edges of the token hunt. A token that arrives as the very last allowed byte must be accepted, and a run of non-token bytes exactly one budget long must time out. The bench reaches both by loading its card model with a counted run of 0x00 filler bytes ahead of a block. It then compares how many bytes were clocked with the budget. A checksum failure in the first of two blocks is provoked by flipping one bit of a stored checksum byte. The bench then confirms that the second block is never clocked in. The frozen link under backpressure is reached by holding the sink off and counting serial clock edges over a long window.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;

   typedef enum logic [1:0] {
      SDRD_OK        = 2'd0,
      SDRD_ERR_TOKEN = 2'd1,
      SDRD_ERR_CRC   = 2'd2
   } sdrd_err_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HUNT,
      ST_DATA,
      ST_CRC_HI,
      ST_CRC_LO,
      ST_DONE
   } sdrd_state_e;

   localparam logic [7:0] SDRD_START_TOKEN = 8'hFE;
   localparam logic [7:0] SDRD_FILL_BYTE   = 8'hFF;

endpackage

// File: rtl/sdrd_spi_byte.sv
module sdrd_spi_byte #(
   parameter int CLK_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sclk,
   output logic       mosi,
   output logic       active,
   output logic       rx_valid,
   output logic [7:0] rx
);

   logic       tick;
   logic       active_q, sclk_q, rx_valid_q;
   logic [2:0] bit_q;
   logic [7:0] tx_sh, rx_sh;

   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DIV_W = $clog2(CLK_DIV);
         logic [DIV_W-1:0] div_q;
         assign tick = (div_q == DIV_W'(CLK_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                div_q <= '0;
            else if (!active_q || tick) div_q <= '0;
            else                       div_q <= div_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         sclk_q     <= 1'b0;
         rx_valid_q <= 1'b0;
         bit_q      <= '0;
         tx_sh      <= 8'hFF;
         rx_sh      <= '0;
      end else begin
         rx_valid_q <= 1'b0;
         if (go && !active_q) begin
            active_q <= 1'b1;
            sclk_q   <= 1'b0;
            bit_q    <= '0;
            tx_sh    <= tx;
         end else if (active_q && tick) begin
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               rx_sh  <= {rx_sh[6:0], miso};
            end else begin
               sclk_q <= 1'b0;
               tx_sh  <= {tx_sh[6:0], 1'b1};
               if (bit_q == 3'd7) begin
                  active_q   <= 1'b0;
                  rx_valid_q <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end
         end
      end
   end

   assign sclk     = sclk_q;
   assign mosi     = tx_sh[7];
   assign active   = active_q;
   assign rx_valid = rx_valid_q;
   assign rx       = rx_sh;

   AST_BYTE_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (!sclk && !active)); // R1

   AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !active); // R1

endmodule

// File: rtl/sdrd_crc16.sv
module sdrd_crc16 #(
   parameter logic [15:0] POLY = 16'h1021
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        upd,
   input  logic [7:0]  din,
   output logic [15:0] crc
);

   function automatic logic [15:0] step_byte(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      logic        fb;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         fb = r[15] ^ b[i];
         r  = {r[14:0], 1'b0};
         if (fb) r = r ^ POLY;
      end
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc <= '0;
      else if (clear) crc <= '0;
      else if (upd)   crc <= step_byte(crc, din);
   end

   AST_NO_CLEAR_AND_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      !(clear && upd)); // R5

endmodule

// File: rtl/sdrd_ctrl.sv
module sdrd_ctrl
   import sdrd_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int SIZE_W     = 12,
   parameter int HUNT_LIMIT = 3000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  blk_count,
   input  logic [SIZE_W-1:0] blk_size,
   input  logic              crc_en,
   output logic              xchg_go,
   input  logic              xchg_active,
   input  logic              rx_valid,
   input  logic [7:0]        rx,
   output logic              crc_clear,
   output logic              crc_upd,
   input  logic [15:0]       crc_val,
   output logic [7:0]        dout,
   output logic              dout_valid,
   input  logic              dout_ready,
   output logic              busy,
   output logic              done,
   output sdrd_err_e         err
);

   localparam int HUNT_W = (HUNT_LIMIT > 1) ? $clog2(HUNT_LIMIT) : 1;
   localparam logic [HUNT_W-1:0] HUNT_LAST = HUNT_W'(HUNT_LIMIT - 1);

   sdrd_state_e       state;
   logic [CNT_W-1:0]  blocks_left;
   logic [SIZE_W-1:0] size_q, bytes_left;
   logic [HUNT_W-1:0] hunt_cnt;
   logic              crc_en_q, waiting, dvalid_q;
   logic [7:0]        dout_q, crc_hi_q;
   sdrd_err_e         err_q;
   logic              in_xfer;

   assign in_xfer   = (state == ST_HUNT) || (state == ST_DATA) ||
                      (state == ST_CRC_HI) || (state == ST_CRC_LO);
   assign xchg_go   = in_xfer && !waiting && !dvalid_q;
   assign crc_clear = (state == ST_HUNT) && rx_valid && (rx == SDRD_START_TOKEN);
   assign crc_upd   = (state == ST_DATA) && rx_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         blocks_left <= '0;
         size_q      <= '0;
         bytes_left  <= '0;
         hunt_cnt    <= '0;
         crc_en_q    <= 1'b0;
         waiting     <= 1'b0;
         dvalid_q    <= 1'b0;
         dout_q      <= '0;
         crc_hi_q    <= '0;
         err_q       <= SDRD_OK;
      end else begin
         if (xchg_go)       waiting <= 1'b1;
         else if (rx_valid) waiting <= 1'b0;
         if (dvalid_q && dout_ready) dvalid_q <= 1'b0;

         case (state)
            ST_IDLE: begin
               if (start) begin
                  err_q       <= SDRD_OK;
                  blocks_left <= blk_count;
                  size_q      <= blk_size;
                  crc_en_q    <= crc_en;
                  hunt_cnt    <= '0;
                  state       <= (blk_count == '0) ? ST_DONE : ST_HUNT;
               end
            end
            ST_HUNT: begin
               if (rx_valid) begin
                  if (rx == SDRD_START_TOKEN) begin
                     bytes_left <= size_q;
                     state      <= (size_q == '0) ? ST_CRC_HI : ST_DATA;
                  end else if (hunt_cnt == HUNT_LAST) begin
                     err_q <= SDRD_ERR_TOKEN;
                     state <= ST_DONE;
                  end else begin
                     hunt_cnt <= hunt_cnt + 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (rx_valid) begin
                  dout_q     <= rx;
                  dvalid_q   <= 1'b1;
                  bytes_left <= bytes_left - 1'b1;
                  if (bytes_left == SIZE_W'(1)) state <= ST_CRC_HI;
               end
            end
            ST_CRC_HI: begin
               if (rx_valid) begin
                  crc_hi_q <= rx;
                  state    <= ST_CRC_LO;
               end
            end
            ST_CRC_LO: begin
               if (rx_valid) begin
                  if (crc_en_q && ({crc_hi_q, rx} != crc_val)) begin
                     err_q <= SDRD_ERR_CRC;
                     state <= ST_DONE;
                  end else if (blocks_left == CNT_W'(1)) begin
                     state <= ST_DONE;
                  end else begin
                     blocks_left <= blocks_left - 1'b1;
                     hunt_cnt    <= '0;
                     state       <= ST_HUNT;
                  end
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign dout       = dout_q;
   assign dout_valid = dvalid_q;
   assign busy       = (state != ST_IDLE);
   assign done       = (state == ST_DONE);
   assign err        = err_q;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_ERR_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      2'(err) != 2'b11); // R3

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!dout_valid && !xchg_active)); // R9

   AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout))); // R8

endmodule

// File: rtl/sdrd_block_reader.sv
module sdrd_block_reader
   import sdrd_pkg::*;
#(
   parameter int CLK_DIV    = 4,
   parameter int CNT_W      = 16,
   parameter int SIZE_W     = 12,
   parameter int HUNT_LIMIT = 3000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  blk_count,
   input  logic [SIZE_W-1:0] blk_size,
   input  logic              crc_en,
   output logic              busy,
   output logic              done,
   output logic [1:0]        err,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [7:0]        dout,
   output logic              dout_valid,
   input  logic              dout_ready
);

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (HUNT_LIMIT < 1) begin : g_bad_hunt
         $error("HUNT_LIMIT must be at least 1");
      end
      if (CNT_W < 1 || SIZE_W < 1) begin : g_bad_width
         $error("CNT_W and SIZE_W must be at least 1");
      end
   endgenerate

   logic        xchg_go, xchg_active, rx_valid;
   logic [7:0]  rx_byte;
   logic        crc_clear, crc_upd;
   logic [15:0] crc_val;
   sdrd_err_e   err_e;

   sdrd_spi_byte #(.CLK_DIV(CLK_DIV)) u_byte (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (xchg_go),
      .tx       (SDRD_FILL_BYTE),
      .miso     (miso),
      .sclk     (sclk),
      .mosi     (mosi),
      .active   (xchg_active),
      .rx_valid (rx_valid),
      .rx       (rx_byte)
   );

   sdrd_crc16 #(.POLY(16'h1021)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (crc_clear),
      .upd   (crc_upd),
      .din   (rx_byte),
      .crc   (crc_val)
   );

   sdrd_ctrl #(
      .CNT_W      (CNT_W),
      .SIZE_W     (SIZE_W),
      .HUNT_LIMIT (HUNT_LIMIT)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .blk_count   (blk_count),
      .blk_size    (blk_size),
      .crc_en      (crc_en),
      .xchg_go     (xchg_go),
      .xchg_active (xchg_active),
      .rx_valid    (rx_valid),
      .rx          (rx_byte),
      .crc_clear   (crc_clear),
      .crc_upd     (crc_upd),
      .crc_val     (crc_val),
      .dout        (dout),
      .dout_valid  (dout_valid),
      .dout_ready  (dout_ready),
      .busy        (busy),
      .done        (done),
      .err         (err_e)
   );

   assign err = err_e;

   AST_LINK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid |-> (!sclk && !xchg_active)); // R8

endmodule

// File: tb/sdrd_block_reader_bench.sv
module sdrd_block_reader_bench;

   localparam int CLK_DIV    = 2;
   localparam int CNT_W      = 4;
   localparam int SIZE_W     = 6;
   localparam int HUNT_LIMIT = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [CNT_W-1:0]  blk_count = '0;
   logic [SIZE_W-1:0] blk_size = '0;
   logic              crc_en = 1'b0;
   logic              busy, done, sclk, mosi, miso, dout_valid;
   logic [1:0]        err;
   logic [7:0]        dout;
   logic              dout_ready = 1'b1;

   always #10 clk = ~clk;

   sdrd_block_reader #(
      .CLK_DIV(CLK_DIV), .CNT_W(CNT_W), .SIZE_W(SIZE_W), .HUNT_LIMIT(HUNT_LIMIT)
   ) u_sdrd_block_reader (
      .clk(clk), .rst_n(rst_n), .start(start), .blk_count(blk_count),
      .blk_size(blk_size), .crc_en(crc_en), .busy(busy), .done(done), .err(err),
      .sclk(sclk), .mosi(mosi), .miso(miso), .dout(dout),
      .dout_valid(dout_valid), .dout_ready(dout_ready)
   );

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // card model
   logic [7:0] card_mem [0:255];
   int card_len = 0, card_ptr = 0, card_bit = 0;
   assign miso = (card_ptr < card_len) ? card_mem[card_ptr][7 - card_bit] : 1'b1;
   always @(negedge sclk) begin
      if (card_bit == 7) begin card_bit = 0; card_ptr = card_ptr + 1; end
      else card_bit = card_bit + 1;
   end

   int sclk_rises = 0, mosi_low = 0;
   always @(posedge sclk) begin
      sclk_rises = sclk_rises + 1;
      if (mosi !== 1'b1) mosi_low = mosi_low + 1;
   end

   // expected payload and sink
   logic [7:0] exp_mem [0:255];
   logic [7:0] got_mem [0:255];
   int exp_n = 0, got_n = 0, ready_mode = 0, ready_ph = 0;
   always @(negedge clk) begin
      ready_ph = ready_ph + 1;
      case (ready_mode)
         0: dout_ready = 1'b1;
         1: dout_ready = (ready_ph % 3) != 0;
         default: dout_ready = 1'b0;
      endcase
      if (dout_valid && dout_ready && got_n < 256) begin
         got_mem[got_n] = dout;
         got_n = got_n + 1;
      end
   end

   always @(posedge clk) begin
      cycles = cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
         else              r = {r[14:0], 1'b0};
      end
      return r;
   endfunction

   task automatic card_reset();
      for (int i = 0; i < 256; i++) card_mem[i] = 8'hFF;
      card_len = 0; card_ptr = 0; card_bit = 0;
      exp_n = 0; got_n = 0; sclk_rises = 0;
   endtask

   task automatic card_put(input logic [7:0] b);
      card_mem[card_len] = b;
      card_len = card_len + 1;
   endtask

   task automatic card_fill(input int n, input logic [7:0] v);
      for (int i = 0; i < n; i++) card_put(v);
   endtask

   task automatic card_block(input int n, input int seed, input bit bad);
      logic [15:0] c;
      logic [7:0]  b;
      c = 16'h0000;
      card_put(8'hFE);
      for (int i = 0; i < n; i++) begin
         b = 8'((seed * 37 + i * 13 + 5) & 255);
         card_put(b);
         exp_mem[exp_n] = b;
         exp_n = exp_n + 1;
         c = crc_step(c, b);
      end
      card_put(c[15:8]);
      card_put(bad ? (c[7:0] ^ 8'h01) : c[7:0]);
   endtask

   task automatic kick(input int cnt, input int size, input bit ce);
      @(negedge clk);
      blk_count = CNT_W'(cnt);
      blk_size  = SIZE_W'(size);
      crc_en    = ce;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         if (done) begin seen = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic check_payload(input string req);
      bit same;
      same = (got_n == exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++)
         if (got_mem[i] !== exp_mem[i]) same = 1'b0;
      chk(got_n == exp_n, req, "payload byte count", got_n, exp_n);
      chk(same, req, "payload contents match", int'(same), 1);
   endtask

   task automatic t_reset();
      chk(!busy && !done && !dout_valid, "R12", "busy/done/valid low", {busy, done, dout_valid}, 0);
      chk(sclk == 1'b0 && mosi == 1'b1, "R12", "sclk low mosi high", {sclk, mosi}, 1);
      chk(err == 2'b00, "R12", "err after reset", err, 0);
   endtask

   task automatic t_known_crc();
      bit seen;
      card_reset();
      card_fill(3, 8'hFF);
      card_put(8'hFE);
      for (int i = 0; i < 9; i++) begin
         card_put(8'h31 + 8'(i));
         exp_mem[i] = 8'h31 + 8'(i);
      end
      exp_n = 9;
      card_put(8'h31); card_put(8'hC3);
      ready_mode = 0;
      kick(1, 9, 1'b1);
      chk(busy == 1'b1, "R9", "busy after start", busy, 1);
      wait_done(seen);
      chk(seen, "R9", "done seen", int'(seen), 1);
      chk(err == 2'b00, "R5", "known CRC 0x31C3 accepted", err, 0);
      check_payload("R4");
      chk(card_ptr == 15, "R2", "bytes clocked incl. filler and CRC", card_ptr, 15);
      chk(mosi_low == 0, "R1", "mosi low bits seen", mosi_low, 0);
      chk(sclk_rises == 15 * 8, "R1", "sclk rising edges", sclk_rises, 120);
      @(negedge clk);
      chk(!done && !busy, "R9", "done one cycle, busy drops", {done, busy}, 0);
   endtask

   task automatic t_multi();
      bit seen;
      card_reset();
      card_fill(2, 8'h00);
      card_block(5, 1, 1'b0);
      card_fill(7, 8'h3C);
      card_block(5, 2, 1'b0);
      card_fill(4, 8'hFF);
      card_block(5, 3, 1'b0);
      ready_mode = 1;
      kick(3, 5, 1'b1);
      wait_done(seen);
      chk(seen && err == 2'b00, "R7", "three blocks ok", err, 0);
      check_payload("R7");
      chk(card_ptr == card_len, "R7", "all card bytes read", card_ptr, card_len);
      ready_mode = 0;
   endtask

   task automatic t_crc_bad();
      bit seen;
      card_reset();
      card_block(4, 7, 1'b1);
      card_block(4, 8, 1'b0);
      exp_n = 4;
      kick(2, 4, 1'b1);
      wait_done(seen);
      chk(seen && err == 2'b10, "R5", "mismatch gives CRC error", err, 2);
      chk(card_ptr == 7, "R5", "no byte read after mismatch", card_ptr, 7);
      check_payload("R5");
      repeat (5) @(negedge clk);
      chk(err == 2'b10, "R9", "err held after done", err, 2);
   endtask

   task automatic t_crc_off();
      bit seen;
      card_reset();
      card_block(4, 9, 1'b1);
      card_block(4, 10, 1'b1);
      kick(2, 4, 1'b0);
      wait_done(seen);
      chk(seen && err == 2'b00, "R6", "bad CRC ignored when disabled", err, 0);
      check_payload("R6");
   endtask

   task automatic t_timeout();
      bit seen;
      card_reset();
      card_fill(HUNT_LIMIT + 4, 8'h00);
      kick(1, 4, 1'b1);
      wait_done(seen);
      chk(seen && err == 2'b01, "R3", "token timeout code", err, 1);
      chk(card_ptr == HUNT_LIMIT, "R3", "bytes hunted", card_ptr, HUNT_LIMIT);
      chk(got_n == 0, "R2", "nothing presented on timeout", got_n, 0);
   endtask

   task automatic t_token_last();
      bit seen;
      card_reset();
      card_fill(HUNT_LIMIT - 1, 8'h00);
      card_block(3, 11, 1'b0);
      card_fill(HUNT_LIMIT - 1, 8'hFF);
      card_block(3, 12, 1'b0);
      kick(2, 3, 1'b1);
      wait_done(seen);
      chk(seen && err == 2'b00, "R3", "token as last allowed byte accepted", err, 0);
      check_payload("R7");
   endtask

   task automatic t_backpressure();
      bit seen, stable;
      logic [7:0] held;
      int rises0;
      card_reset();
      card_block(4, 13, 1'b0);
      ready_mode = 2;
      kick(1, 4, 1'b1);
      for (int i = 0; i < 2000 && !dout_valid; i++) @(negedge clk);
      held = dout;
      rises0 = sclk_rises;
      stable = 1'b1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (dout !== held || !dout_valid || sclk) stable = 1'b0;
      end
      chk(stable, "R8", "dout held and link frozen", int'(stable), 1);
      chk(sclk_rises == rises0, "R8", "sclk edges while stalled", sclk_rises - rises0, 0);
      ready_mode = 0;
      wait_done(seen);
      chk(seen && err == 2'b00, "R8", "completes after release", err, 0);
      check_payload("R8");
   endtask

   task automatic t_start_busy();
      bit seen;
      card_reset();
      card_block(3, 14, 1'b0);
      kick(1, 3, 1'b1);
      repeat (40) @(negedge clk);
      kick(3, 9, 1'b0);
      wait_done(seen);
      chk(seen && err == 2'b00, "R10", "second start ignored", err, 0);
      check_payload("R10");
      repeat (100) @(negedge clk);
      chk(!busy && card_ptr == 6, "R10", "no restart after done", card_ptr, 6);
   endtask

   task automatic t_zero();
      bit seen;
      card_reset();
      card_block(3, 15, 1'b0);
      kick(0, 3, 1'b1);
      wait_done(seen);
      chk(seen && err == 2'b00, "R11", "zero count done ok", err, 0);
      chk(sclk_rises == 0, "R11", "no sclk activity", sclk_rises, 0);
   endtask

   initial begin
      card_reset();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_known_crc();
      t_multi();
      t_crc_bad();
      t_crc_off();
      t_timeout();
      t_token_last();
      t_backpressure();
      t_start_busy();
      t_zero();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule